// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between one I/O device and memory on its own, so that the processor does not perform each move. Software writes the transfer direction, the device address, the first memory address and the number of words. It then sets a start bit and goes on with other work.

For every word, the engine raises a bus request and waits for the grant. It then runs the bus cycles for that one word and drops the request, so the processor loses the bus only for a few cycles at a time and keeps its context. When the last word is done, the engine raises an interrupt. The interrupt stays high until software clears it.

A parameter selects between two attachments:
- **Detached:** the device sits on the shared bus. Each word is read into the engine on one bus cycle and written out on a second bus cycle.
- **Integrated:** the device hangs off a private port of the engine. Each word then takes a single bus cycle, and the device strobe fires in that same cycle.

Top module: `cs_dma`

## Requirements
- R1: After reset `bus_req_o`, `bus_valid_o`, `dev_stb_o` and `irq_o` are low, and every register reads zero.
- R2: Register map on `cfg_addr_i`:
  - 0 is control. Bit 0 is write-only start. Bit 1 is direction: 0 moves device to memory, 1 moves memory to device.
  - 1 is the device address.
  - 2 is the memory address, which reads the current value.
  - 3 is the word count, which reads the remaining count.
  - 4 is status. Bit 0 is the interrupt flag. Bit 1 is busy.
  - Written values read back.
- R3: `bus_valid_o` is high only while both `bus_req_o` and `bus_gnt_i` are high. While the grant is withheld, no bus cycle occurs.
- R4: Each grant carries exactly one word. After the last bus cycle of a word, `bus_req_o` is low for at least one cycle, so a block of N words gives N rising edges of `bus_req_o`.
- R5: In detached mode each word takes two consecutive bus cycles.
  - Device to memory: a device read (`bus_io_o`=1, `bus_we_o`=0, device address), then a memory write (`bus_io_o`=0) of the same data.
  - Memory to device: a memory read, then a device write of the read data.
  - `dev_stb_o` stays low.
- R6: In integrated mode each word takes one bus cycle, always with `bus_io_o`=0, and `dev_stb_o` is high in that cycle.
  - Device to memory: a memory write of `dev_rdata_i`, with `dev_we_o`=0.
  - Memory to device: a memory read, with `dev_we_o`=1 and `dev_wdata_o` carrying `bus_rdata_i`.
- R7: After each word the memory address goes up by one and the count goes down by one. The block ends when the count reaches zero.
- R8: `irq_o` rises when the block ends. It stays high until status is written with bit 0 set. Writing status with bit 0 clear leaves it high.
- R9: A start with a count of zero raises `irq_o` on the clock edge of the write, and runs no bus cycle.
- R10: While busy, writes to the control, device, memory and count registers are ignored, including a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | DW | Register write data |
| cfg_rdata_o | output | DW | Register read data |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_valid_o | output | 1 | Bus cycle active this clock |
| bus_io_o | output | 1 | Cycle targets I/O space (1) or memory (0) |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| dev_stb_o | output | 1 | Private device port strobe (integrated mode) |
| dev_we_o | output | 1 | Private device port write |
| dev_addr_o | output | AW | Private device port address |
| dev_wdata_o | output | DW | Private device port write data |
| dev_rdata_i | input | DW | Private device port read data |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions check the following on every cycle:
- the bus handshake, with no bus cycle outside request and grant;
- the release of the request after each word;
- the alternation of I/O and memory cycles in detached mode, and the single-cycle device strobe in integrated mode;
- the interrupt holding until it is cleared.

Several properties can only be shown by the bench's scenarios:
- the order and content of the transactions;
- the address and count bookkeeping;
- the zero-count start;
- ignored writes while a grant is withheld.

The bench shows these by running both modes side by side against a scoreboard of expected bus cycles.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] REG_DEV  = 3'd1;
  localparam logic [REG_AW-1:0] REG_MEM  = 3'd2;
  localparam logic [REG_AW-1:0] REG_CNT  = 3'd3;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd4;
  localparam int CTRL_GO   = 0;
  localparam int CTRL_DIR  = 1;
  localparam int STAT_IRQ  = 0;
  localparam int STAT_BUSY = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_PH1, ST_PH2, ST_REL
  } seq_st_e;
endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              word_done_i,
  output logic              go_o,
  output logic              last_o,
  output logic              dir_o,
  output logic [AW-1:0]     dev_addr_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              irq_o
);
  logic          dir_q, irq_q;
  logic [AW-1:0] dev_q, mem_q;
  logic [CW-1:0] cnt_q;
  logic          wr_idle, start_cmd;

  assign wr_idle   = we_i && !busy_i;
  assign start_cmd = wr_idle && (addr_i == REG_CTRL) && wdata_i[CTRL_GO];
  assign go_o      = start_cmd && (cnt_q != '0);
  assign last_o    = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
      dev_q <= '0;
      mem_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (we_i && (addr_i == REG_STAT) && wdata_i[STAT_IRQ]) irq_q <= 1'b0;
      if (wr_idle) begin
        unique case (addr_i)
          REG_CTRL: dir_q <= wdata_i[CTRL_DIR];
          REG_DEV:  dev_q <= wdata_i[AW-1:0];
          REG_MEM:  mem_q <= wdata_i[AW-1:0];
          REG_CNT:  cnt_q <= wdata_i[CW-1:0];
          default: ;
        endcase
      end
      if (start_cmd && (cnt_q == '0)) irq_q <= 1'b1;
      if (word_done_i) begin
        mem_q <= mem_q + AW'(1);
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o[CTRL_DIR] = dir_q;
      REG_DEV:  rdata_o[AW-1:0]   = dev_q;
      REG_MEM:  rdata_o[AW-1:0]   = mem_q;
      REG_CNT:  rdata_o[CW-1:0]   = cnt_q;
      REG_STAT: begin
        rdata_o[STAT_IRQ]  = irq_q;
        rdata_o[STAT_BUSY] = busy_i;
      end
      default: ;
    endcase
  end

  assign dir_o      = dir_q;
  assign dev_addr_o = dev_q;
  assign mem_addr_o = mem_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
  import cs_dma_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter bit DETACHED = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          last_i,
  input  logic          dir_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [AW-1:0] mem_addr_i,
  output logic          busy_o,
  output logic          word_done_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_valid_o,
  output logic          bus_io_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          dev_stb_o,
  output logic          dev_we_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic [DW-1:0] dev_rdata_i
);
  seq_st_e       st_q, st_d;
  logic [DW-1:0] hold_q;
  logic          fin_phase;

  // last bus cycle of a word: second phase when detached, first otherwise
  assign fin_phase = DETACHED ? (st_q == ST_PH2) : (st_q == ST_PH1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go_i) st_d = ST_REQ;
      ST_REQ:  if (bus_gnt_i) st_d = ST_PH1;
      ST_PH1:  st_d = DETACHED ? ST_PH2 : (last_i ? ST_IDLE : ST_REL);
      ST_PH2:  st_d = last_i ? ST_IDLE : ST_REL;
      ST_REL:  st_d = ST_REQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_PH1) hold_q <= bus_rdata_i;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign word_done_o = fin_phase;
  assign bus_req_o   = (st_q == ST_REQ) || (st_q == ST_PH1) || (st_q == ST_PH2);
  assign bus_valid_o = (st_q == ST_PH1) || (st_q == ST_PH2);

  always_comb begin
    bus_io_o    = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    dev_stb_o   = 1'b0;
    dev_we_o    = 1'b0;
    dev_wdata_o = '0;
    if (DETACHED) begin
      if (st_q == ST_PH1) begin
        // fetch: from the device when filling memory, else from memory
        bus_io_o   = !dir_i;
        bus_addr_o = dir_i ? mem_addr_i : dev_addr_i;
      end else if (st_q == ST_PH2) begin
        bus_io_o    = dir_i;
        bus_we_o    = 1'b1;
        bus_addr_o  = dir_i ? dev_addr_i : mem_addr_i;
        bus_wdata_o = hold_q;
      end
    end else if (st_q == ST_PH1) begin
      bus_addr_o  = mem_addr_i;
      bus_we_o    = !dir_i;
      bus_wdata_o = dir_i ? '0 : dev_rdata_i;
      dev_stb_o   = 1'b1;
      dev_we_o    = dir_i;
      dev_wdata_o = dir_i ? bus_rdata_i : '0;
    end
  end
endmodule

// File: rtl/cs_dma.sv
module cs_dma
  import cs_dma_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter bit DETACHED = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [DW-1:0]     cfg_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_valid_o,
  output logic              bus_io_o,
  output logic              bus_we_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic [DW-1:0]     bus_rdata_i,
  output logic              dev_stb_o,
  output logic              dev_we_o,
  output logic [AW-1:0]     dev_addr_o,
  output logic [DW-1:0]     dev_wdata_o,
  input  logic [DW-1:0]     dev_rdata_i,
  output logic              irq_o
);
  logic          busy, word_done, go, last, dir;
  logic [AW-1:0] dev_addr, mem_addr;

  cs_dma_regs #(.DW(DW), .AW(AW), .CW(CW)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .busy_i      (busy),
    .word_done_i (word_done),
    .go_o        (go),
    .last_o      (last),
    .dir_o       (dir),
    .dev_addr_o  (dev_addr),
    .mem_addr_o  (mem_addr),
    .irq_o       (irq_o)
  );

  cs_dma_seq #(.DW(DW), .AW(AW), .DETACHED(DETACHED)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .last_i      (last),
    .dir_i       (dir),
    .dev_addr_i  (dev_addr),
    .mem_addr_i  (mem_addr),
    .busy_o      (busy),
    .word_done_o (word_done),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_valid_o (bus_valid_o),
    .bus_io_o    (bus_io_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .dev_stb_o   (dev_stb_o),
    .dev_we_o    (dev_we_o),
    .dev_wdata_o (dev_wdata_o),
    .dev_rdata_i (dev_rdata_i)
  );

  assign dev_addr_o = dev_addr;
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk
  import cs_dma_pkg::*;
#(
  parameter int DW       = 16,
  parameter bit DETACHED = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_valid_o,
  input logic              bus_io_o,
  input logic              dev_stb_o,
  input logic              irq_o,
  input logic              cfg_we_i,
  input logic [REG_AW-1:0] cfg_addr_i,
  input logic [DW-1:0]     cfg_wdata_i
);
  logic irq_clr;
  assign irq_clr = cfg_we_i && (cfg_addr_i == REG_STAT) && cfg_wdata_i[STAT_IRQ];

  AST_VALID_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> (bus_req_o && bus_gnt_i)); // R3

  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr) |=> irq_o); // R8

  AST_IRQ_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !bus_req_o); // R9

  if (DETACHED) begin : g_det
    AST_TWO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_o && !$past(bus_valid_o)) |=> bus_valid_o); // R5
    AST_RELEASE_AFTER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_o && $past(bus_valid_o)) |=> !bus_req_o); // R4
    AST_SPACE_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_o && $past(bus_valid_o)) |-> (bus_io_o != $past(bus_io_o))); // R5
    AST_NO_DEV_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dev_stb_o); // R5
  end else begin : g_int
    AST_RELEASE_AFTER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_valid_o |=> (!bus_req_o && !bus_valid_o)); // R4
    AST_SINGLE_MEM_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_valid_o |-> (!bus_io_o && dev_stb_o)); // R6
    AST_STB_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dev_stb_o |-> bus_valid_o); // R6
  end
endmodule

bind cs_dma cs_dma_chk #(.DW(DW), .DETACHED(DETACHED)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_valid_o (bus_valid_o),
  .bus_io_o    (bus_io_o),
  .dev_stb_o   (dev_stb_o),
  .irq_o       (irq_o),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i)
);

// File: tb/cs_dma_tb_top.sv
module cs_dma_tb_top;
  import cs_dma_pkg::*;
  localparam int DW = 16;
  localparam int AW = 16;

  typedef struct packed {
    logic          io;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } xfer_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic              cfg_we = 1'b0;
  logic [REG_AW-1:0] cfg_addr = '0;
  logic [DW-1:0]     cfg_wdata = '0;
  logic              hold = 1'b0;
  logic [DW-1:0]     dev_pat = 16'h0;

  // detached instance (dut_i) signals: _d; integrated instance: _n
  logic [DW-1:0] rdata_d, rdata_n, bwd_d, bwd_n, brd_d, brd_n, dwd_d, dwd_n;
  logic [AW-1:0] badr_d, badr_n, dadr_d, dadr_n;
  logic req_d, req_n, gnt_d, gnt_n, val_d, val_n, io_d, io_n, bwe_d, bwe_n;
  logic stb_d, stb_n, dwe_d, dwe_n, irq_d, irq_n;

  logic [DW-1:0] mem_d [16];
  logic [DW-1:0] mem_n [16];
  logic [DW-1:0] exp_mem [16];

  cs_dma #(.DW(DW), .AW(AW), .CW(16), .DETACHED(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rdata_d), .bus_req_o(req_d),
    .bus_gnt_i(gnt_d), .bus_valid_o(val_d), .bus_io_o(io_d), .bus_we_o(bwe_d),
    .bus_addr_o(badr_d), .bus_wdata_o(bwd_d), .bus_rdata_i(brd_d),
    .dev_stb_o(stb_d), .dev_we_o(dwe_d), .dev_addr_o(dadr_d),
    .dev_wdata_o(dwd_d), .dev_rdata_i(dev_pat), .irq_o(irq_d));

  cs_dma #(.DW(DW), .AW(AW), .CW(16), .DETACHED(1'b0)) dut_int_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(rdata_n), .bus_req_o(req_n),
    .bus_gnt_i(gnt_n), .bus_valid_o(val_n), .bus_io_o(io_n), .bus_we_o(bwe_n),
    .bus_addr_o(badr_n), .bus_wdata_o(bwd_n), .bus_rdata_i(brd_n),
    .dev_stb_o(stb_n), .dev_we_o(dwe_n), .dev_addr_o(dadr_n),
    .dev_wdata_o(dwd_n), .dev_rdata_i(dev_pat), .irq_o(irq_n));

  // bus model: arbiter grants one cycle after request unless held off
  assign brd_d = io_d ? dev_pat : mem_d[badr_d[3:0]];
  assign brd_n = mem_n[badr_n[3:0]];

  int valid_cnt_d = 0, valid_cnt_n = 0, rises_d = 0, rises_n = 0;
  logic req_pd = 1'b0, req_pn = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_d <= 1'b0; gnt_n <= 1'b0; req_pd <= 1'b0; req_pn <= 1'b0;
      for (int i = 0; i < 16; i++) begin
        mem_d[i] <= DW'(16'h0100 + i * 16'h0101);
        mem_n[i] <= DW'(16'h0100 + i * 16'h0101);
      end
    end else begin
      gnt_d <= req_d && !hold;
      gnt_n <= req_n && !hold;
      req_pd <= req_d; req_pn <= req_n;
      if (req_d && !req_pd) rises_d <= rises_d + 1;
      if (req_n && !req_pn) rises_n <= rises_n + 1;
      if (val_d) valid_cnt_d <= valid_cnt_d + 1;
      if (val_n) valid_cnt_n <= valid_cnt_n + 1;
      if (val_d && bwe_d && !io_d) mem_d[badr_d[3:0]] <= bwd_d;
      if (val_n && bwe_n) mem_n[badr_n[3:0]] <= bwd_n;
    end
  end

  int checks = 0, errors = 0;
  xfer_t q_d[$];
  xfer_t q_n[$];
  logic [AW-1:0] exp_dev = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitors: pop expected cycles as the designs produce them
  always @(negedge clk) begin
    if (rst_n && val_d) begin
      if (q_d.size() == 0) chk(1'b0, "R5 unexpected detached cycle", {io_d, bwe_d, badr_d}, 0);
      else begin
        xfer_t e;
        e = q_d.pop_front();
        chk(io_d == e.io && bwe_d == e.we && badr_d == e.addr, "R5 detached cycle kind",
            {14'd0, io_d, bwe_d, badr_d}, {14'd0, e.io, e.we, e.addr});
        if (e.we) chk(bwd_d == e.data, "R5 detached data", bwd_d, e.data);
      end
    end
    if (rst_n && val_n) begin
      if (q_n.size() == 0) chk(1'b0, "R6 unexpected integrated cycle", {io_n, bwe_n, badr_n}, 0);
      else begin
        xfer_t e;
        e = q_n.pop_front();
        chk(!io_n && bwe_n == e.we && badr_n == e.addr && stb_n && dwe_n == !e.we &&
            dadr_n == exp_dev, "R6 integrated cycle kind",
            {12'd0, io_n, bwe_n, stb_n, dwe_n, badr_n}, {12'd0, 1'b0, e.we, 1'b1, !e.we, e.addr});
        if (e.we) chk(bwd_n == e.data, "R6 integrated mem data", bwd_n, e.data);
        else chk(dwd_n == e.data, "R6 integrated dev data", dwd_n, e.data);
      end
    end
  end

  task automatic wr(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [DW-1:0] vd, output logic [DW-1:0] vn);
    cfg_addr = a;
    #1;
    vd = rdata_d; vn = rdata_n;
  endtask

  // driver: queues the expected bus cycles of a block, then programs it
  task automatic program_block(input bit dir, input int dev, input int mem, input int n);
    exp_dev = AW'(dev);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] m;
      logic [DW-1:0] v;
      m = AW'(mem + k);
      if (!dir) begin
        v = dev_pat;
        q_d.push_back('{1'b1, 1'b0, AW'(dev), v});
        q_d.push_back('{1'b0, 1'b1, m, v});
        q_n.push_back('{1'b0, 1'b1, m, v});
        exp_mem[m[3:0]] = v;
      end else begin
        v = exp_mem[m[3:0]];
        q_d.push_back('{1'b0, 1'b0, m, v});
        q_d.push_back('{1'b1, 1'b1, AW'(dev), v});
        q_n.push_back('{1'b0, 1'b0, m, v});
      end
    end
    rises_d = 0; rises_n = 0;
    wr(REG_DEV, DW'(dev));
    wr(REG_MEM, DW'(mem));
    wr(REG_CNT, DW'(n));
  endtask

  task automatic finish_block(input int mem, input int n);
    logic [DW-1:0] vd, vn;
    int t;
    t = 0;
    while (!(irq_d && irq_n) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(irq_d && irq_n, "R8 irq at block end", {irq_d, irq_n}, 2'b11);
    chk(q_d.size() == 0, "R5 all detached cycles seen", q_d.size(), 0);
    chk(q_n.size() == 0, "R6 all integrated cycles seen", q_n.size(), 0);
    chk(rises_d == n && rises_n == n, "R4 one request per word", {rises_d[15:0], rises_n[15:0]},
        {n[15:0], n[15:0]});
    rd(REG_MEM, vd, vn);
    chk(vd == DW'(mem + n) && vn == DW'(mem + n), "R7 memory address advanced", {vd, vn},
        {DW'(mem + n), DW'(mem + n)});
    rd(REG_CNT, vd, vn);
    chk(vd == 0 && vn == 0, "R7 count reached zero", {vd, vn}, 0);
    rd(REG_STAT, vd, vn);
    chk(vd == 16'h1 && vn == 16'h1, "R2 status irq set, idle", {vd, vn}, 32'h0001_0001);
    repeat (4) @(negedge clk);
    chk(irq_d && irq_n, "R8 irq held", {irq_d, irq_n}, 2'b11);
    wr(REG_STAT, 16'h0);
    chk(irq_d && irq_n, "R8 write without bit0 keeps irq", {irq_d, irq_n}, 2'b11);
    wr(REG_STAT, 16'h1);
    chk(!irq_d && !irq_n, "R8 irq cleared", {irq_d, irq_n}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] vd, vn;
    int vc_d, vc_n;
    for (int i = 0; i < 16; i++) exp_mem[i] = DW'(16'h0100 + i * 16'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(!req_d && !req_n && !val_d && !val_n && !stb_n && !irq_d && !irq_n,
        "R1 outputs idle after reset", {req_d, req_n, val_d, val_n, stb_n, irq_d, irq_n}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(REG_AW'(a), vd, vn);
      chk(vd == 0 && vn == 0, "R1 register zero after reset", {vd, vn}, 0);
    end

    wr(REG_DEV, 16'h0021);
    wr(REG_MEM, 16'h0033);
    wr(REG_CNT, 16'h0044);
    wr(REG_CTRL, 16'h0002);
    rd(REG_DEV, vd, vn);
    chk(vd == 16'h21 && vn == 16'h21, "R2 device address readback", {vd, vn}, 32'h0021_0021);
    rd(REG_MEM, vd, vn);
    chk(vd == 16'h33 && vn == 16'h33, "R2 memory address readback", {vd, vn}, 32'h0033_0033);
    rd(REG_CNT, vd, vn);
    chk(vd == 16'h44 && vn == 16'h44, "R2 count readback", {vd, vn}, 32'h0044_0044);
    rd(REG_CTRL, vd, vn);
    chk(vd == 16'h2 && vn == 16'h2, "R2 direction readback", {vd, vn}, 32'h0002_0002);
    chk(!req_d && !req_n, "R2 no start without go bit", {req_d, req_n}, 0);

    // device to memory, four words
    dev_pat = 16'h5A01;
    program_block(1'b0, 5, 2, 4);
    wr(REG_CTRL, 16'h0001);
    finish_block(2, 4);

    // memory to device, three words including words just written
    dev_pat = 16'h0;
    program_block(1'b1, 9, 4, 3);
    wr(REG_CTRL, 16'h0003);
    finish_block(4, 3);

    // single word at the top of the model memory
    dev_pat = 16'hC3C3;
    program_block(1'b0, 7, 15, 1);
    wr(REG_CTRL, 16'h0001);
    finish_block(15, 1);

    // zero count: immediate irq, no bus cycle
    vc_d = valid_cnt_d; vc_n = valid_cnt_n;
    wr(REG_CNT, 16'h0);
    wr(REG_CTRL, 16'h0001);
    chk(irq_d && irq_n, "R9 zero count irq at once", {irq_d, irq_n}, 2'b11);
    repeat (5) @(negedge clk);
    chk(valid_cnt_d == vc_d && valid_cnt_n == vc_n && !req_d && !req_n,
        "R9 zero count runs no bus cycle", {valid_cnt_d[15:0], valid_cnt_n[15:0]},
        {vc_d[15:0], vc_n[15:0]});
    wr(REG_STAT, 16'h1);

    // grant withheld: no cycles, config writes ignored while busy
    hold = 1'b1;
    dev_pat = 16'h7E11;
    program_block(1'b0, 3, 8, 2);
    vc_d = valid_cnt_d; vc_n = valid_cnt_n;
    wr(REG_CTRL, 16'h0001);
    repeat (6) @(negedge clk);
    chk(req_d && req_n && valid_cnt_d == vc_d && valid_cnt_n == vc_n,
        "R3 request waits, no cycle without grant", {req_d, req_n, valid_cnt_d[15:0]},
        {2'b11, vc_d[15:0]});
    wr(REG_MEM, 16'h0030);
    wr(REG_CNT, 16'h0007);
    wr(REG_DEV, 16'h0055);
    wr(REG_CTRL, 16'h0003);
    rd(REG_MEM, vd, vn);
    chk(vd == 16'h8 && vn == 16'h8, "R10 memory address write ignored", {vd, vn}, 32'h0008_0008);
    rd(REG_CNT, vd, vn);
    chk(vd == 16'h2 && vn == 16'h2, "R10 count write ignored", {vd, vn}, 32'h0002_0002);
    rd(REG_CTRL, vd, vn);
    chk(vd == 16'h0 && vn == 16'h0, "R10 direction write ignored", {vd, vn}, 0);
    rd(REG_STAT, vd, vn);
    chk(vd == 16'h2 && vn == 16'h2, "R2 busy while waiting", {vd, vn}, 32'h0002_0002);
    hold = 1'b0;
    finish_block(8, 2);

    repeat (5) @(negedge clk);
    chk(!req_d && !req_n && q_d.size() == 0 && q_n.size() == 0,
        "R10 restart attempt left no extra work", {req_d, req_n}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule